// File: doc/BRIEF.md
# Vectored Dual-Class Interrupt Controller

This block collects 64 level-sensitive interrupt sources and turns them into two processor-facing requests: a normal-class request and a fast-class request. Software reaches it through a 32-bit word-addressed register port. Through that port it can enable each source, place each source in the normal or the fast class, give each source a 4-bit priority, and force any source active regardless of its input level.

For the normal class, a combinational arbiter selects the pending source with the greatest priority. The winner is reported in a vector/status word, and a global threshold can hold it back. For the fast class, the highest-numbered pending source is reported in its own vector/status word. Either vector word reads 0xFFFF in its upper half when its class has nothing to report. An interrupt handler can therefore read the normal vector repeatedly until it sees that sentinel.

Register reads are registered: data requested in one cycle appears on `bus_rdata` in the next cycle. Register writes take effect at the clock edge that samples them.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, all enable, type and force bits are zero, the threshold is zero, both request outputs are low, and both vector words (0x40 normal, 0x44 fast) read 0xFFFF0000.
- R2: Enable bits can be written and read as two words: sources 0–31 at 0x14 and sources 32–63 at 0x10, with bit i of a word covering source i of that half.
- R3: Writing a number N to 0x08 sets the enable bit of source N. Only bits 5:0 of the written data are used, and no other enable bit changes.
- R4: Writing a number N to 0x0C clears the enable bit of source N. No other enable bit changes.
- R5: A type bit of 1 (0x1C for the low half, 0x18 for the high half) puts a source in the fast class; a type bit of 0 puts it in the normal class. Pending words show (level OR force) AND enable for each class: normal at 0x5C/0x58, fast at 0x64/0x60 (low/high).
- R6: Force bits (0x54 low, 0x50 high) make a source active exactly as a high input level does.
- R7: The normal vector word carries, in bits 31:16, the number of the normal pending source with the greatest priority. When priorities are equal, the higher source number wins. Bits 15:0 read zero.
- R8: Priority register x (x = 0..7) sits at 0x20 + 4*(7−x). Its bits [4k+3:4k] hold the priority of source 8x+k. These registers read back what was written.
- R9: The threshold at 0x04 (5 bits) suppresses the normal winner when the winner's priority is at or below the threshold. While suppressed, `irq_norm_o` is low and the normal vector reads 0xFFFF0000. A threshold of 0x1F blocks every normal source.
- R10: The fast vector word carries the highest-numbered fast pending source in bits 31:16, or 0xFFFF when none is pending. `irq_fast_o` is high exactly when some fast source is pending.
- R11: The raw input levels read back at 0x4C (sources 0–31) and 0x48 (sources 32–63).
- R12: The control word at 0x00 stores any 32-bit value written to it and has no effect on interrupt behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; data follows one cycle later |
| bus_addr | input | 7 | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_lvl | input | 64 | Source levels, active high |
| irq_norm_o | output | 1 | Normal-class request |
| irq_fast_o | output | 1 | Fast-class request |

## Verification
The assertions assume that `bus_we` and `bus_re` are never high in the same cycle. They also assume that every access uses an address taken from the register map. For enable-number and disable-number writes, they assume the data's low six bits name the intended source. The bench meets these assumptions by issuing one access at a time through its write and read tasks, always with a named map offset. It changes `src_lvl` only at falling edges and clears both strobes between accesses.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NSRC_DEF = 64;
  localparam int PRIO_W   = 4;
  localparam int THR_W    = 5;
  localparam logic [15:0] NO_VEC = 16'hFFFF;

  // pack a winner number into the upper half of a vector/status word
  function automatic logic [31:0] vec_word(input logic ok, input logic [15:0] id);
    return ok ? {id, 16'h0000} : {NO_VEC, 16'h0000};
  endfunction

  // byte offset of priority register x
  function automatic logic [6:0] prio_addr(input int x);
    return 7'(32 + 4 * (7 - x));
  endfunction
endpackage

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
  import irq_vec_pkg::*;
#(
  parameter int NSRC = NSRC_DEF,
  localparam int IDW = $clog2(NSRC),
  localparam int NPR = NSRC / 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [6:0]             bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            ctrl_q,
  output logic [THR_W-1:0]       thr_q,
  output logic [NSRC-1:0]        en_q,
  output logic [NSRC-1:0]        typ_q,
  output logic [NSRC-1:0]        frc_q,
  output logic [NSRC*PRIO_W-1:0] prio_q
);
  logic [IDW-1:0] wnum;
  assign wnum = bus_wdata[IDW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      thr_q  <= '0;
      en_q   <= '0;
      typ_q  <= '0;
      frc_q  <= '0;
      prio_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        7'h00: ctrl_q <= bus_wdata;
        7'h04: thr_q <= bus_wdata[THR_W-1:0];
        7'h08: en_q[wnum] <= 1'b1;
        7'h0C: en_q[wnum] <= 1'b0;
        7'h10: en_q[63:32] <= bus_wdata;
        7'h14: en_q[31:0] <= bus_wdata;
        7'h18: typ_q[63:32] <= bus_wdata;
        7'h1C: typ_q[31:0] <= bus_wdata;
        7'h50: frc_q[63:32] <= bus_wdata;
        7'h54: frc_q[31:0] <= bus_wdata;
        default: begin
          for (int x = 0; x < NPR; x++)
            if (bus_addr == prio_addr(x))
              prio_q[x*32 +: 32] <= bus_wdata;
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_norm_arb.sv
module irq_norm_arb
  import irq_vec_pkg::*;
#(
  parameter int NSRC = NSRC_DEF,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        pend,
  input  logic [NSRC*PRIO_W-1:0] prio,
  output logic                   win_valid,
  output logic [IDW-1:0]         win_id,
  output logic [PRIO_W-1:0]      win_prio
);
  // ascending scan with >= so an equal priority moves the winner upward
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_prio  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (!win_valid || prio[i*PRIO_W +: PRIO_W] >= win_prio)) begin
        win_valid = 1'b1;
        win_id    = IDW'(i);
        win_prio  = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_fast_pick.sv
module irq_fast_pick
  import irq_vec_pkg::*;
#(
  parameter int NSRC = NSRC_DEF,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] pend,
  output logic            pick_valid,
  output logic [IDW-1:0]  pick_id
);
  always_comb begin
    pick_valid = 1'b0;
    pick_id    = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i]) begin
        pick_valid = 1'b1;
        pick_id    = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int NSRC = NSRC_DEF,
  localparam int IDW = $clog2(NSRC),
  localparam int NPR = NSRC / 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [6:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [63:0] src_lvl,
  output logic        irq_norm_o,
  output logic        irq_fast_o
);
  logic [31:0]            ctrl_q;
  logic [THR_W-1:0]       thr_q;
  logic [NSRC-1:0]        en_q, typ_q, frc_q;
  logic [NSRC*PRIO_W-1:0] prio_q;
  logic [NSRC-1:0]        active, pend_norm, pend_fast;
  logic                   win_valid, fast_valid, norm_ok;
  logic [IDW-1:0]         win_id, fast_id;
  logic [PRIO_W-1:0]      win_prio;
  logic [31:0]            nvec, fvec, rd_mux;

  irq_vec_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .thr_q(thr_q), .en_q(en_q),
    .typ_q(typ_q), .frc_q(frc_q), .prio_q(prio_q)
  );

  assign active    = (src_lvl | frc_q) & en_q;
  assign pend_norm = active & ~typ_q;
  assign pend_fast = active & typ_q;

  irq_norm_arb #(.NSRC(NSRC)) u_arb (
    .pend(pend_norm), .prio(prio_q),
    .win_valid(win_valid), .win_id(win_id), .win_prio(win_prio)
  );

  irq_fast_pick #(.NSRC(NSRC)) u_fast (
    .pend(pend_fast), .pick_valid(fast_valid), .pick_id(fast_id)
  );

  assign norm_ok    = win_valid && ({1'b0, win_prio} > thr_q);
  assign irq_norm_o = norm_ok;
  assign irq_fast_o = fast_valid;
  assign nvec = vec_word(norm_ok, 16'(win_id));
  assign fvec = vec_word(fast_valid, 16'(fast_id));

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      7'h00: rd_mux = ctrl_q;
      7'h04: rd_mux = 32'(thr_q);
      7'h10: rd_mux = en_q[63:32];
      7'h14: rd_mux = en_q[31:0];
      7'h18: rd_mux = typ_q[63:32];
      7'h1C: rd_mux = typ_q[31:0];
      7'h40: rd_mux = nvec;
      7'h44: rd_mux = fvec;
      7'h48: rd_mux = src_lvl[63:32];
      7'h4C: rd_mux = src_lvl[31:0];
      7'h50: rd_mux = frc_q[63:32];
      7'h54: rd_mux = frc_q[31:0];
      7'h58: rd_mux = pend_norm[63:32];
      7'h5C: rd_mux = pend_norm[31:0];
      7'h60: rd_mux = pend_fast[63:32];
      7'h64: rd_mux = pend_fast[31:0];
      default: begin
        for (int x = 0; x < NPR; x++)
          if (bus_addr == prio_addr(x)) rd_mux = prio_q[x*32 +: 32];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk #(
  parameter int NSRC = 64,
  parameter int IDW  = 6,
  parameter int PW   = 4,
  parameter int TW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [6:0]      bus_addr,
  input logic [IDW-1:0]  wnum,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] pend_norm,
  input logic [NSRC-1:0] pend_fast,
  input logic [IDW-1:0]  win_id,
  input logic [PW-1:0]   win_prio,
  input logic [TW-1:0]   thr_q,
  input logic [IDW-1:0]  fast_id,
  input logic            irq_norm_o,
  input logic            irq_fast_o
);
  AST_ENNUM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 7'h08) |=> en_q[$past(wnum)]); // R3
  AST_DISNUM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 7'h0C) |=> !en_q[$past(wnum)]); // R4
  AST_CLASS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_norm & pend_fast) == '0); // R5
  AST_NORM_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm_o |-> ({1'b0, win_prio} > thr_q)); // R9
  AST_NORM_WIN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm_o |-> pend_norm[win_id]); // R7
  AST_FAST_ID_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast_o |-> pend_fast[fast_id]); // R10
  AST_FAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_fast_o |-> pend_fast == '0); // R10
endmodule

bind irq_vec_ctrl irq_vec_chk #(.NSRC(NSRC), .IDW(IDW), .PW(irq_vec_pkg::PRIO_W), .TW(irq_vec_pkg::THR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .wnum(bus_wdata[IDW-1:0]), .en_q(en_q), .pend_norm(pend_norm),
  .pend_fast(pend_fast), .win_id(win_id), .win_prio(win_prio),
  .thr_q(thr_q), .fast_id(fast_id), .irq_norm_o(irq_norm_o),
  .irq_fast_o(irq_fast_o)
);

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_lvl = '0;
  logic        irq_norm_o, irq_fast_o;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];
  logic rd_seen = 1'b0;

  always #5 clk = ~clk;

  irq_vec_ctrl u_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_lvl(src_lvl), .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
  );

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  // driver: issue a read and push its expected value
  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    it.exp = e; it.tag = tag; sbq.push_back(it);
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic pins(input logic n, input logic f, input string tag);
    #1;
    total++;
    if (irq_norm_o !== n || irq_fast_o !== f) begin
      bad++;
      $display("FAIL %s: norm/fast=%b%b expected %b%b", tag, irq_norm_o, irq_fast_o, n, f);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_re;

  // monitor: pop and compare once registered read data is out
  always @(negedge clk) begin
    if (rd_seen) begin
      item_t it;
      total++;
      if (sbq.size() == 0) begin
        bad++; $display("FAIL scoreboard: read data with no expectation");
      end else begin
        it = sbq.pop_front();
        if (bus_rdata !== it.exp) begin
          bad++;
          $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pins(1'b0, 1'b0, "R1 outputs after reset");
    rd(7'h40, 32'hFFFF0000, "R1 normal vector idle");
    rd(7'h44, 32'hFFFF0000, "R1 fast vector idle");
    rd(7'h14, 32'h0, "R1 enables low");
    rd(7'h18, 32'h0, "R1 types high");

    wr(7'h08, 32'd5);
    wr(7'h08, 32'd40);
    rd(7'h14, 32'h0000_0020, "R3 enable-number low half");
    rd(7'h10, 32'h0000_0100, "R2 enable high half");
    wr(7'h08, 32'h0000_00C7);        // only bits 5:0 count -> source 7
    rd(7'h14, 32'h0000_00A0, "R3 upper data bits ignored");
    wr(7'h0C, 32'd5);
    rd(7'h14, 32'h0000_0080, "R4 disable-number");
    rd(7'h10, 32'h0000_0100, "R4 other half untouched");

    @(negedge clk); src_lvl = (64'd1 << 7) | (64'd1 << 40);
    pins(1'b0, 1'b0, "R9 priority 0 at threshold 0");
    rd(7'h40, 32'hFFFF0000, "R9 suppressed vector");
    rd(7'h5C, 32'h0000_0080, "R5 normal pending low");
    rd(7'h58, 32'h0000_0100, "R5 normal pending high");
    rd(7'h4C, 32'h0000_0080, "R11 raw low");
    rd(7'h48, 32'h0000_0100, "R11 raw high");

    wr(7'h3C, 32'h3000_0000);        // register 0 field 7 -> source 7
    wr(7'h28, 32'h0000_0002);        // register 5 field 0 -> source 40
    rd(7'h28, 32'h0000_0002, "R8 priority readback");
    pins(1'b1, 1'b0, "R7 normal request");
    rd(7'h40, 32'h0007_0000, "R7 higher priority wins");

    wr(7'h04, 32'd3);
    pins(1'b0, 1'b0, "R9 winner equal to threshold");
    rd(7'h40, 32'hFFFF0000, "R9 vector at threshold");
    wr(7'h04, 32'd2);
    pins(1'b1, 1'b0, "R9 winner above threshold");
    wr(7'h04, 32'h1F);
    pins(1'b0, 1'b0, "R9 all blocked");
    wr(7'h04, 32'd0);

    wr(7'h28, 32'h0000_0003);
    rd(7'h40, 32'h0028_0000, "R7 tie goes to higher number");

    wr(7'h18, 32'h0000_0100);        // source 40 to fast class
    pins(1'b1, 1'b1, "R5 both classes active");
    rd(7'h40, 32'h0007_0000, "R5 normal after steering");
    rd(7'h44, 32'h0028_0000, "R10 fast vector");
    rd(7'h60, 32'h0000_0100, "R5 fast pending high");
    rd(7'h58, 32'h0, "R5 normal pending high cleared");

    wr(7'h08, 32'd63);
    wr(7'h18, 32'h8000_0100);
    wr(7'h50, 32'h8000_0000);        // force source 63
    rd(7'h44, 32'h003F_0000, "R6 forced source wins fast");
    rd(7'h60, 32'h8000_0100, "R6 forced pending");

    @(negedge clk); src_lvl = '0;
    pins(1'b0, 1'b1, "R6 force holds without level");
    wr(7'h50, 32'h0);
    pins(1'b0, 1'b0, "R10 nothing pending");
    rd(7'h44, 32'hFFFF0000, "R10 fast sentinel");
    rd(7'h40, 32'hFFFF0000, "R7 normal sentinel");

    wr(7'h00, 32'h1234_5678);
    rd(7'h00, 32'h1234_5678, "R12 control storage");
    pins(1'b0, 1'b0, "R12 no effect on requests");
    wr(7'h14, 32'hFFFF_0000);
    rd(7'h14, 32'hFFFF_0000, "R2 enable low word write");

    repeat (3) @(negedge clk);
    total++;
    if (sbq.size() != 0) begin
      bad++; $display("FAIL scoreboard: %0d items left, expected 0", sbq.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule